// File: doc/BRIEF.md
# Open-Drain Parallel I/O Port

This block runs a small set of general-purpose pins for a serial codec interface. Each pin can only be pulled low or released, and an external resistor pulls it high. Writing a zero to a pin's bit turns its pulldown on. Writing a one releases the pin, so another device may drive it. To use a pin as an input, software first writes a one to it and then reads the level back.

The port has two modes, selected by a mode input. In data mode, software writes the pins and reads them back through a data register. Both actions are aligned to frame-sync rising edges, and the serial clock plays no part. Read data appears one frame after it is sampled. In control mode the pins are read only. They are sampled on a chosen serial-clock rising edge inside the frame, and the value is returned in that same frame.

The serial clock and frame sync arrive as levels that are synchronous to the block clock, and the block detects their rising edges. The pin inputs are asynchronous. They pass through a two-flop synchronizer before any sampling.

Top module: `pio_od_port`

## Requirements
- R1: After reset, every pulldown enable is 0 (all pins released), and both read-back outputs (`data_rd_o`, `ctrl_rd_o`) are all ones.
- R2: A pin whose applied write bit is 0 has its pulldown enable at 1. A pin whose applied write bit is 1 has its pulldown enable at 0 (bit i of `wr_data_i` controls pin i).
- R3: A write is accepted when `wr_valid_i` is 1 while `data_mode_i` is 1. It changes the pulldown enables in the clock cycle after the first frame-sync rising edge seen strictly after the write. A write in the same cycle as a frame-sync edge waits for the next edge. When several writes fall between two frame edges, the last one wins.
- R4: Writes while `data_mode_i` is 0 are ignored. A pending data-mode write is dropped if `data_mode_i` falls before the frame edge that would apply it.
- R5: Pin inputs pass through two synchronizer flops. A level driven on `pin_i` is seen by a sampling edge only from the second clock edge after the first edge that registers it.
- R6: At each data-mode frame-sync rising edge, the synchronized pin levels are captured. `data_rd_o` shows the previous capture from that edge on, so there is one frame of latency. The value is the real pin level, not the written value.
- R7: In control mode, a frame-sync rising edge arms the sampler. The (SAMPLE_EDGE+1)-th serial-clock rising edge after it loads the synchronized pins into `ctrl_rd_o`, in the same frame. After that, `ctrl_rd_o` holds until the next armed sample, so there is at most one sample per frame.
- R8: Data-mode frame edges leave `ctrl_rd_o` unchanged. Control-mode frame edges leave `pd_en_o` and `data_rd_o` unchanged.
- R9: Serial-clock edges in data mode have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock level, synchronous to clk |
| fsync_i | input | 1 | Frame sync level, synchronous to clk |
| data_mode_i | input | 1 | 1 = data mode, 0 = control mode |
| wr_valid_i | input | 1 | Write strobe for the pin data register |
| wr_data_i | input | NPIN | Pin write value, 0 = pull low, 1 = release |
| pin_i | input | NPIN | Asynchronous pin levels |
| pd_en_o | output | NPIN | Pulldown enables, 1 = pin driven low |
| data_rd_o | output | NPIN | Data-mode read-back, one frame late |
| ctrl_rd_o | output | NPIN | Control-mode read-back, same frame |

## Verification
A vector table runs six data-mode frames that mix writes and no-writes with varied pin levels. It includes a frame where the pins read high even though zero was written. This separates the applied write value from the sampled level and shows the one-frame read latency. Directed cases then cover several timing corners:
- a write that coincides with a frame edge, and back-to-back writes;
- a write dropped by a mode change;
- control-mode sampling with a second serial-clock edge in the same frame;
- pin changes placed one and two cycles before the sampling edge, which expose the synchronizer depth;
- a reset taken mid-operation.

// File: rtl/pio_od_pkg.sv
package pio_od_pkg;

    typedef enum logic {
        MODE_CTRL = 1'b0,
        MODE_DATA = 1'b1
    } pio_mode_e;

    typedef struct packed {
        logic sclk;
        logic fsync;
    } pio_lvl_t;

endpackage

// File: rtl/pio_od_edge.sv
module pio_od_edge
    import pio_od_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic fsync_i,
    output logic sclk_rise_o,
    output logic fsync_rise_o
);

    pio_lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d.sclk   = sclk_i;
        lvl_d.fsync  = fsync_i;
        sclk_rise_o  = sclk_i & ~lvl_q.sclk;
        fsync_rise_o = fsync_i & ~lvl_q.fsync;
    end

    // Reset high so a level already high at reset release is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '{sclk: 1'b1, fsync: 1'b1};
        else        lvl_q <= lvl_d;
    end

    AST_FRAME_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_rise_o |=> !fsync_rise_o); // R3

    AST_SCLK_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise_o |=> !sclk_rise_o); // R7

endmodule

// File: rtl/pio_od_sync.sv
module pio_od_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    // Released pins idle high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pio_od_data.sv
module pio_od_data #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_mode_i,
    input  logic         frame_i,
    input  logic         wr_valid_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] pin_s_i,
    output logic [W-1:0] pd_en_o,
    output logic [W-1:0] rd_o
);

    typedef struct packed {
        logic [W-1:0] pend;
        logic         pend_vld;
        logic [W-1:0] drive;   // 1 = released, 0 = pulled low
        logic [W-1:0] capt;
        logic [W-1:0] rd;
    } dat_st_t;

    dat_st_t st_d, st_q;
    logic    frame_en;
    logic    accept;

    always_comb begin
        st_d     = st_q;
        frame_en = data_mode_i & frame_i;
        accept   = data_mode_i & wr_valid_i;

        if (frame_en) begin
            if (st_q.pend_vld) st_d.drive = st_q.pend;
            st_d.pend_vld = 1'b0;
            st_d.capt     = pin_s_i;
            st_d.rd       = st_q.capt;
        end
        if (accept) begin
            st_d.pend     = wr_data_i;
            st_d.pend_vld = 1'b1;
        end
        if (!data_mode_i) st_d.pend_vld = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: '1, pend_vld: 1'b0, drive: '1, capt: '1, rd: '1};
        else        st_q <= st_d;
    end

    assign pd_en_o = ~st_q.drive;
    assign rd_o    = st_q.rd;

    AST_DRIVE_AT_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.drive) |-> $past(data_mode_i && frame_i)); // R3

    AST_PEND_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_mode_i && frame_i && st_q.pend_vld) |=> st_q.drive == $past(st_q.pend)); // R3

    AST_CTRL_MODE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!data_mode_i) |-> $stable(pd_en_o)); // R4

    AST_RD_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_o) |-> $past(data_mode_i && frame_i)); // R6

endmodule

// File: rtl/pio_od_ctrl.sv
module pio_od_ctrl #(
    parameter int W               = 2,
    parameter int SCLKS_PER_FRAME = 32,
    parameter int SAMPLE_EDGE     = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_mode_i,
    input  logic         frame_i,
    input  logic         sclk_rise_i,
    input  logic [W-1:0] pin_s_i,
    output logic [W-1:0] rd_o
);

    localparam int              CNT_W  = (SCLKS_PER_FRAME > 2) ? $clog2(SCLKS_PER_FRAME) : 1;
    localparam logic [CNT_W-1:0] TARGET = CNT_W'(SAMPLE_EDGE);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rd;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (data_mode_i) begin
            st_d.armed = 1'b0;
        end else if (frame_i) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (sclk_rise_i && st_q.armed) begin
            if (st_q.cnt == TARGET) begin
                st_d.rd    = pin_s_i;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b0, cnt: '0, rd: '1};
        else        st_q <= st_d;
    end

    assign rd_o = st_q.rd;

    AST_CTRL_RD_ON_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_o) |-> $past(sclk_rise_i && !data_mode_i)); // R7

    AST_ONE_SAMPLE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_o) |-> !st_q.armed); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TARGET); // R7

    AST_DATA_MODE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(data_mode_i) |-> !st_q.armed); // R9

endmodule

// File: rtl/pio_od_port.sv
module pio_od_port
    import pio_od_pkg::*;
#(
    parameter int NPIN            = 2,
    parameter int SYNC_STAGES     = 2,
    parameter int SCLKS_PER_FRAME = 32,
    parameter int SAMPLE_EDGE     = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            fsync_i,
    input  logic            data_mode_i,
    input  logic            wr_valid_i,
    input  logic [NPIN-1:0] wr_data_i,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] pd_en_o,
    output logic [NPIN-1:0] data_rd_o,
    output logic [NPIN-1:0] ctrl_rd_o
);

    pio_mode_e       mode;
    logic            sclk_rise;
    logic            fsync_rise;
    logic [NPIN-1:0] pin_s;

    assign mode = pio_mode_e'(data_mode_i);

    pio_od_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .fsync_i     (fsync_i),
        .sclk_rise_o (sclk_rise),
        .fsync_rise_o(fsync_rise)
    );

    pio_od_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (pin_s)
    );

    pio_od_data #(.W(NPIN)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_mode_i(mode == MODE_DATA),
        .frame_i    (fsync_rise),
        .wr_valid_i (wr_valid_i),
        .wr_data_i  (wr_data_i),
        .pin_s_i    (pin_s),
        .pd_en_o    (pd_en_o),
        .rd_o       (data_rd_o)
    );

    pio_od_ctrl #(
        .W              (NPIN),
        .SCLKS_PER_FRAME(SCLKS_PER_FRAME),
        .SAMPLE_EDGE    (SAMPLE_EDGE)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_mode_i(mode == MODE_DATA),
        .frame_i    (fsync_rise),
        .sclk_rise_i(sclk_rise),
        .pin_s_i    (pin_s),
        .rd_o       (ctrl_rd_o)
    );

    // Cycle count since reset, so the latency check never reaches into reset.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    generate
        if (SYNC_STAGES == 2) begin : g_sync_chk
            AST_PIN_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == 2'd3) |-> pin_s == $past(pin_i, 2)); // R5
        end
    endgenerate

    AST_CTRL_FRAME_KEEPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fsync_rise && !data_mode_i) |-> $stable(pd_en_o) && $stable(data_rd_o)); // R8

    AST_DATA_FRAME_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fsync_rise && data_mode_i) |-> $stable(ctrl_rd_o)); // R8

endmodule

// File: tb/pio_od_port_bench.sv
`timescale 1ns/1ps
module pio_od_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_i = 1'b0;
    logic       fsync_i = 1'b0;
    logic       data_mode_i = 1'b1;
    logic       wr_valid_i = 1'b0;
    logic [1:0] wr_data_i = 2'b11;
    logic [1:0] pin_i = 2'b11;
    logic [1:0] pd_en_o, data_rd_o, ctrl_rd_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pio_od_port u_pio_od_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk_i),
        .fsync_i    (fsync_i),
        .data_mode_i(data_mode_i),
        .wr_valid_i (wr_valid_i),
        .wr_data_i  (wr_data_i),
        .pin_i      (pin_i),
        .pd_en_o    (pd_en_o),
        .data_rd_o  (data_rd_o),
        .ctrl_rd_o  (ctrl_rd_o)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] wdata;
        logic [1:0] pins;
        logic [1:0] exp_pd;
        logic [1:0] exp_rd;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b1, 2'b10, 2'b01, 2'b01, 2'b11},
        '{1'b0, 2'b00, 2'b10, 2'b01, 2'b01},
        '{1'b1, 2'b00, 2'b00, 2'b11, 2'b10},
        '{1'b1, 2'b11, 2'b11, 2'b00, 2'b00},
        '{1'b1, 2'b01, 2'b11, 2'b10, 2'b11},
        '{1'b0, 2'b00, 2'b10, 2'b10, 2'b11}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic frame_edge();
        fsync_i = 1'b1;
        tick(1);
        fsync_i = 1'b0;
    endtask

    task automatic sclk_edge();
        sclk_i = 1'b1;
        tick(1);
        sclk_i = 1'b0;
    endtask

    task automatic write(input logic [1:0] d);
        wr_valid_i = 1'b1;
        wr_data_i  = d;
        tick(1);
        wr_valid_i = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [1:0] prev_pd;
        logic [1:0] hold;
        tick(3);
        check("R1", "pd_en in reset", pd_en_o, 2'b00);
        rst_n = 1'b1;
        tick(1);
        check("R1", "pd_en after reset", pd_en_o, 2'b00);
        check("R1", "data_rd after reset", data_rd_o, 2'b11);
        check("R1", "ctrl_rd after reset", ctrl_rd_o, 2'b11);

        // Data-mode frames from the vector table (R2, R3, R6, R9)
        prev_pd = 2'b00;
        for (int k = 0; k < 6; k++) begin
            pin_i = VEC[k].pins;
            if (VEC[k].wr) write(VEC[k].wdata);
            tick(3);
            check("R3", "pd_en before frame edge", pd_en_o, prev_pd);
            frame_edge();
            check("R2", "pd_en after frame edge", pd_en_o, VEC[k].exp_pd);
            check("R6", "data_rd one frame late", data_rd_o, VEC[k].exp_rd);
            sclk_edge();
            check("R9", "ctrl_rd under data-mode sclk", ctrl_rd_o, 2'b11);
            prev_pd = VEC[k].exp_pd;
        end

        // R3: write together with a frame edge waits for the next one
        wr_valid_i = 1'b1; wr_data_i = 2'b11; fsync_i = 1'b1;
        tick(1);
        wr_valid_i = 1'b0; fsync_i = 1'b0;
        check("R3", "same-cycle write not applied", pd_en_o, 2'b10);
        tick(3);
        frame_edge();
        check("R3", "same-cycle write applied next frame", pd_en_o, 2'b00);

        // R3: last of several writes wins
        write(2'b00);
        write(2'b01);
        tick(2);
        frame_edge();
        check("R3", "last write wins", pd_en_o, 2'b10);

        // R4: pending write dropped by a mode change
        write(2'b00);
        data_mode_i = 1'b0;
        tick(2);
        data_mode_i = 1'b1;
        tick(2);
        frame_edge();
        check("R4", "dropped pending write", pd_en_o, 2'b10);

        // Control mode: R4, R7, R8
        data_mode_i = 1'b0;
        hold = data_rd_o;
        write(2'b00);
        pin_i = 2'b01;
        tick(3);
        frame_edge();
        check("R4", "control-mode write ignored", pd_en_o, 2'b10);
        check("R8", "data_rd kept at control frame", data_rd_o, hold);
        check("R7", "ctrl_rd holds before sclk", ctrl_rd_o, 2'b11);
        sclk_edge();
        check("R7", "ctrl_rd sampled same frame", ctrl_rd_o, 2'b01);
        pin_i = 2'b10;
        tick(3);
        sclk_edge();
        check("R7", "second sclk edge ignored", ctrl_rd_o, 2'b01);

        // R5: synchronizer depth
        pin_i = 2'b11;
        tick(3);
        frame_edge();
        sclk_edge();
        check("R7", "ctrl_rd new frame", ctrl_rd_o, 2'b11);
        frame_edge();
        pin_i = 2'b00;
        tick(1);
        sclk_edge();
        check("R5", "pin change one cycle early is not seen", ctrl_rd_o, 2'b11);
        tick(3);
        frame_edge();
        pin_i = 2'b01;
        tick(2);
        sclk_edge();
        check("R5", "pin change two cycles early is seen", ctrl_rd_o, 2'b01);

        // R8, R9: data-mode frame and sclk leave ctrl_rd alone
        data_mode_i = 1'b1;
        pin_i = 2'b10;
        tick(3);
        frame_edge();
        check("R8", "ctrl_rd kept at data frame", ctrl_rd_o, 2'b01);
        sclk_edge();
        check("R9", "ctrl_rd kept at data-mode sclk", ctrl_rd_o, 2'b01);

        // R1: reset mid-operation
        write(2'b00);
        tick(1);
        frame_edge();
        check("R2", "all pins pulled low", pd_en_o, 2'b11);
        rst_n = 1'b0;
        tick(2);
        check("R1", "pd_en after mid reset", pd_en_o, 2'b00);
        check("R1", "data_rd after mid reset", data_rd_o, 2'b11);
        check("R1", "ctrl_rd after mid reset", ctrl_rd_o, 2'b11);
        rst_n = 1'b1;
        tick(2);

        done = 1'b1;
        report();
    end

endmodule